// File: doc/BRIEF.md
# Multi-Mode Timer with Capture

A general-purpose hardware timer. A programmable prescaler divides the clock and feeds an up counter, which is compared every step against a programmable compare value. Four counting modes decide what happens on a compare match: stop, restart from zero, restart from zero while inverting an output pin, or keep counting. Instead of prescaled clock ticks, the counter can also advance on chosen edges of an external event pin.

A capture pin, synchronised and edge-qualified, either stores the live count into a capture register or clears the counter, as selected by a configuration input. Timeout and capture events set sticky flags, which a one-cycle strobe clears. Either event can also raise a one-cycle trigger pulse for neighbouring logic. Configuration is presented as static inputs. Start and stop are one-cycle pulses.

Top module: `gp_timer`

## Requirements
- R1: After reset, `busy`, `count`, `capture`, `tmo_flag`, `cap_flag`, `tog_out` and `trig_out` are all zero.
- R2: A `start` pulse clears the counter and prescaler and sets `busy` at the next edge. In clock mode (`evt_count_en`=0) the count then rises by one every `prescale`+1 cycles, the first step landing `prescale`+1 edges after the start edge. `stop` sets `busy` to zero and wins over `start`.
- R3: While `busy` is low, `count` holds its value except for a `start` pulse or a capture clear.
- R4: `mode`=00 (one-shot): when a step would make the count equal `compare`, the counter returns to 0, `busy` falls and `tmo_flag` sets on that edge.
- R5: `mode`=01 (periodic): on the same match the counter returns to 0, `tmo_flag` sets and `busy` stays high.
- R6: `mode`=10 (toggle): behaves like periodic and additionally inverts `tog_out` on each match. `tog_out` changes at no other time.
- R7: `mode`=11 (continuous): on a match `tmo_flag` sets and the count keeps increasing past `compare`, wrapping at 2^24.
- R8: With `evt_count_en`=1, the count steps once per synchronised `evt_pin` edge of the kind chosen by `evt_edge` (00 none, 01 rising, 10 falling, 11 both), and `prescale` has no effect.
- R9: With `cap_clr_cnt`=0, a `cap_pin` edge of the kind chosen by `cap_edge` (same code as R8) loads `capture` with the count and sets `cap_flag`. This happens on the third rising clock edge after the pin changes. Edges of an unselected kind are ignored.
- R10: With `cap_clr_cnt`=1, a qualifying capture edge clears the counter instead, taking priority over a step in that cycle. It sets `cap_flag` and leaves `capture` unchanged.
- R11: `tmo_flag` and `cap_flag` stay set until their clear strobe (`tmo_clr`, `cap_clr`) is high for one cycle. A new event in the same cycle wins over the clear.
- R12: `trig_out` is high for one cycle, on the same edge the flag sets, for a timeout when `trig_on_tmo`=1 and for a capture when `trig_on_cap`=1. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: clear counter and begin running |
| stop | input | 1 | Pulse: halt counting |
| mode | input | 2 | Counting mode (00 one-shot, 01 periodic, 10 toggle, 11 continuous) |
| prescale | input | 8 | Clock divider minus one |
| compare | input | 24 | Compare value |
| evt_count_en | input | 1 | 1: count event pin edges instead of prescaled ticks |
| evt_pin | input | 1 | External event pin (asynchronous) |
| evt_edge | input | 2 | Event edge kind |
| cap_pin | input | 1 | Capture pin (asynchronous) |
| cap_edge | input | 2 | Capture edge kind |
| cap_clr_cnt | input | 1 | 1: capture edge clears counter, 0: latches count |
| tmo_clr | input | 1 | Strobe: clear timeout flag |
| cap_clr | input | 1 | Strobe: clear capture flag |
| trig_on_tmo | input | 1 | Timeout drives trigger |
| trig_on_cap | input | 1 | Capture drives trigger |
| busy | output | 1 | Timer running |
| count | output | 24 | Live counter value |
| capture | output | 24 | Captured counter value |
| tmo_flag | output | 1 | Sticky timeout flag |
| cap_flag | output | 1 | Sticky capture flag |
| tog_out | output | 1 | Toggle-mode output |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
The checker watches rules that hold on every cycle. The count only steps by one, holds, or returns to zero. It is frozen while idle. One-shot drops `busy` after a match, and continuous mode keeps it. `tog_out` moves only after a match. The flags stay sticky until cleared, and a trigger never occurs without a set flag. The directed scenarios are needed for the exact timing: the prescaler period, the match cycle in each mode, the three-edge capture latency and the captured value, edge-kind filtering on both pins, and trigger masking.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
   typedef enum logic [1:0] {
      MODE_ONESHOT  = 2'b00,
      MODE_PERIODIC = 2'b01,
      MODE_TOGGLE   = 2'b10,
      MODE_FREE     = 2'b11
   } tmr_mode_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/gp_timer_edge.sv
module gp_timer_edge
   import gp_timer_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      din,
   input  edge_sel_e sel,
   output logic      pulse
);
   logic [STAGES-1:0] chain;
   logic              last;
   logic              cur;
   logic              rise;
   logic              fall;

   if (STAGES < 1) begin : g_bad_stages
      $error("gp_timer_edge: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= din;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], din};
      end
   end

   assign cur = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else        last <= cur;
   end

   assign rise = cur & ~last;
   assign fall = ~cur & last;

   always_comb begin
      unique case (sel)
         EDGE_RISE: pulse = rise;
         EDGE_FALL: pulse = fall;
         EDGE_BOTH: pulse = rise | fall;
         default:   pulse = 1'b0;
      endcase
   end
endmodule

// File: rtl/gp_timer_presc.sv
module gp_timer_presc #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             evt_mode,
   input  logic             evt_pulse,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] pcnt;
   logic             wrap;

   assign wrap = (pcnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (!run || restart || evt_mode) begin
         pcnt <= '0;
      end else if (wrap) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end

   assign tick = run & ~restart & (evt_mode ? evt_pulse : wrap);
endmodule

// File: rtl/gp_timer_count.sv
module gp_timer_count
   import gp_timer_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic             cap_wipe,
   input  tmr_mode_e        mode,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             match,
   output logic             tog
);
   logic [CNT_W-1:0] nxt;
   logic             step;

   assign step  = tick & ~cap_wipe & ~restart;
   assign nxt   = cnt + 1'b1;
   assign match = step & (nxt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || cap_wipe) begin
         cnt <= '0;
      end else if (step) begin
         if (match && mode != MODE_FREE) cnt <= '0;
         else                            cnt <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             tog <= 1'b0;
      else if (match && mode == MODE_TOGGLE)  tog <= ~tog;
   end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
   import gp_timer_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int PSC_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [1:0]       mode,
   input  logic [PSC_W-1:0] prescale,
   input  logic [CNT_W-1:0] compare,
   input  logic             evt_count_en,
   input  logic             evt_pin,
   input  logic [1:0]       evt_edge,
   input  logic             cap_pin,
   input  logic [1:0]       cap_edge,
   input  logic             cap_clr_cnt,
   input  logic             tmo_clr,
   input  logic             cap_clr,
   input  logic             trig_on_tmo,
   input  logic             trig_on_cap,
   output logic             busy,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] capture,
   output logic             tmo_flag,
   output logic             cap_flag,
   output logic             tog_out,
   output logic             trig_out
);
   localparam int MIN_CNT_W = 2;

   if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
      $error("gp_timer: CNT_W too small");
   end
   if (PSC_W < 1) begin : g_bad_psc
      $error("gp_timer: PSC_W must be at least 1");
   end

   tmr_mode_e mode_e;
   logic      evt_pulse;
   logic      cap_evt;
   logic      cap_rst_evt;
   logic      cap_latch_evt;
   logic      tick;
   logic      match_evt;

   assign mode_e = tmr_mode_e'(mode);

   gp_timer_edge #(.STAGES(SYNC_STAGES)) u_evt_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (evt_pin),
      .sel   (edge_sel_e'(evt_edge)),
      .pulse (evt_pulse)
   );

   gp_timer_edge #(.STAGES(SYNC_STAGES)) u_cap_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cap_pin),
      .sel   (edge_sel_e'(cap_edge)),
      .pulse (cap_evt)
   );

   assign cap_rst_evt   = cap_evt & cap_clr_cnt;
   assign cap_latch_evt = cap_evt & ~cap_clr_cnt;

   gp_timer_presc #(.PSC_W(PSC_W)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .restart   (start),
      .evt_mode  (evt_count_en),
      .evt_pulse (evt_pulse),
      .div       (prescale),
      .tick      (tick)
   );

   gp_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .restart  (start),
      .cap_wipe (cap_rst_evt),
      .mode     (mode_e),
      .cmp      (compare),
      .cnt      (count),
      .match    (match_evt),
      .tog      (tog_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  busy <= 1'b0;
      else if (stop)                               busy <= 1'b0;
      else if (match_evt && mode_e == MODE_ONESHOT) busy <= 1'b0;
      else if (start)                              busy <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             capture <= '0;
      else if (cap_latch_evt) capture <= count;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tmo_flag <= 1'b0;
      else if (match_evt) tmo_flag <= 1'b1;
      else if (tmo_clr)   tmo_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_flag <= 1'b0;
      else if (cap_evt) cap_flag <= 1'b1;
      else if (cap_clr) cap_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_out <= 1'b0;
      else        trig_out <= (match_evt & trig_on_tmo) | (cap_evt & trig_on_cap);
   end
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk
   import gp_timer_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             stop,
   input logic [1:0]       mode,
   input logic             tmo_clr,
   input logic             cap_clr,
   input logic             busy,
   input logic [CNT_W-1:0] count,
   input logic             tmo_flag,
   input logic             cap_flag,
   input logic             tog_out,
   input logic             trig_out,
   input logic             match_evt,
   input logic             cap_rst_evt
);
   // R2: the count steps by one, holds, or returns to zero
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

   // R3: idle counter is frozen
   a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start && !cap_rst_evt) |=> $stable(count));

   // R4: one-shot halts after a match
   a_r4_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && mode == MODE_ONESHOT) |=> !busy);

   // R6: toggle output changes only after a match
   a_r6_tog_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_out != $past(tog_out)) |-> $past(match_evt));

   // R7: continuous mode keeps running through a match
   a_r7_free_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && match_evt && mode == MODE_FREE && !stop) |=> busy);

   // R11: sticky flags
   a_r11_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_flag && !tmo_clr) |=> tmo_flag);
   a_r11_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag && !cap_clr) |=> cap_flag);

   // R12: a trigger always comes with a set flag
   a_r12_trig_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> (tmo_flag || cap_flag));
endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .stop        (stop),
   .mode        (mode),
   .tmo_clr     (tmo_clr),
   .cap_clr     (cap_clr),
   .busy        (busy),
   .count       (count),
   .tmo_flag    (tmo_flag),
   .cap_flag    (cap_flag),
   .tog_out     (tog_out),
   .trig_out    (trig_out),
   .match_evt   (match_evt),
   .cap_rst_evt (cap_rst_evt)
);

// File: tb/gp_timer_tb.sv
module gp_timer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYCLES = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, stop = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [7:0]  prescale = 8'd0;
   logic [23:0] compare = 24'd0;
   logic        evt_count_en = 1'b0, evt_pin = 1'b0;
   logic [1:0]  evt_edge = 2'b00;
   logic        cap_pin = 1'b0;
   logic [1:0]  cap_edge = 2'b00;
   logic        cap_clr_cnt = 1'b0;
   logic        tmo_clr = 1'b0, cap_clr = 1'b0;
   logic        trig_on_tmo = 1'b0, trig_on_cap = 1'b0;
   logic        busy;
   logic [23:0] count, capture;
   logic        tmo_flag, cap_flag, tog_out, trig_out;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gp_timer u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .mode(mode),
      .prescale(prescale), .compare(compare), .evt_count_en(evt_count_en),
      .evt_pin(evt_pin), .evt_edge(evt_edge), .cap_pin(cap_pin),
      .cap_edge(cap_edge), .cap_clr_cnt(cap_clr_cnt), .tmo_clr(tmo_clr),
      .cap_clr(cap_clr), .trig_on_tmo(trig_on_tmo), .trig_on_cap(trig_on_cap),
      .busy(busy), .count(count), .capture(capture), .tmo_flag(tmo_flag),
      .cap_flag(cap_flag), .tog_out(tog_out), .trig_out(trig_out)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_stop();
      stop = 1'b1; @(negedge clk); stop = 1'b0;
   endtask

   task automatic clear_flags();
      tmo_clr = 1'b1; cap_clr = 1'b1; @(negedge clk);
      tmo_clr = 1'b0; cap_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "busy", busy, 0);
      chk("R1", "count", count, 0);
      chk("R1", "capture", capture, 0);
      chk("R1", "flags", {tmo_flag, cap_flag}, 0);
      chk("R1", "tog/trig", {tog_out, trig_out}, 0);
   endtask

   task automatic t_periodic_prescale();
      mode = 2'b01; prescale = 8'd2; compare = 24'd4; trig_on_tmo = 1'b1;
      pulse_start();                       // after start edge E0
      wait_n(2); chk("R2", "count before first step", count, 0);
      wait_n(1); chk("R2", "first step", count, 1);
      wait_n(3); chk("R2", "second step", count, 2);
      wait_n(6);
      chk("R5", "count reload", count, 0);
      chk("R5", "tmo_flag", tmo_flag, 1);
      chk("R5", "busy", busy, 1);
      chk("R12", "trig on timeout", trig_out, 1);
      wait_n(1); chk("R12", "trig one cycle", trig_out, 0);
      wait_n(2); chk("R5", "restarted count", count, 1);
      pulse_stop();
      chk("R2", "stop", busy, 0);
      wait_n(5); chk("R3", "frozen count", count, 1);
      tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
      chk("R11", "tmo cleared", tmo_flag, 0);
   endtask

   task automatic t_oneshot();
      mode = 2'b00; prescale = 8'd0; compare = 24'd3;
      pulse_start();
      chk("R2", "start clears count", count, 0);
      wait_n(2); chk("R4", "count", count, 2);
      wait_n(1);
      chk("R4", "count zero", count, 0);
      chk("R4", "busy dropped", busy, 0);
      chk("R4", "tmo_flag", tmo_flag, 1);
      wait_n(4); chk("R4", "stays stopped", count, 0);
      wait_n(3); chk("R11", "flag sticky", tmo_flag, 1);
      clear_flags();
   endtask

   task automatic t_toggle();
      mode = 2'b10; prescale = 8'd0; compare = 24'd2;
      pulse_start();
      wait_n(1); chk("R6", "tog before match", tog_out, 0);
      wait_n(1); chk("R6", "tog first match", tog_out, 1);
      chk("R6", "count reload", count, 0);
      wait_n(2); chk("R6", "tog second match", tog_out, 0);
      pulse_stop();
      clear_flags();
   endtask

   task automatic t_continuous();
      mode = 2'b11; prescale = 8'd0; compare = 24'd3; trig_on_tmo = 1'b0;
      pulse_start();
      wait_n(3);
      chk("R7", "count at match", count, 3);
      chk("R7", "tmo_flag", tmo_flag, 1);
      chk("R12", "timeout trigger masked", trig_out, 0);
      wait_n(2);
      chk("R7", "count past compare", count, 5);
      chk("R7", "busy", busy, 1);
      pulse_stop();
      clear_flags();
   endtask

   task automatic pulse_evt();
      evt_pin = 1'b1; wait_n(4); evt_pin = 1'b0; wait_n(4);
   endtask

   task automatic t_event();
      mode = 2'b11; compare = 24'hFFFFFF; prescale = 8'd5;
      evt_count_en = 1'b1; evt_edge = 2'b01;
      pulse_start();
      wait_n(10); chk("R8", "no ticks without edges", count, 0);
      pulse_evt(); pulse_evt(); pulse_evt();
      chk("R8", "rising edges counted", count, 3);
      evt_edge = 2'b00;
      pulse_evt();
      chk("R8", "edge kind none ignored", count, 3);
      evt_edge = 2'b10;
      evt_pin = 1'b1; wait_n(4);
      chk("R8", "rising ignored in falling mode", count, 3);
      evt_pin = 1'b0; wait_n(4);
      chk("R8", "falling edge counted", count, 4);
      pulse_stop();
      evt_count_en = 1'b0; evt_edge = 2'b00;
   endtask

   task automatic t_capture_latch();
      mode = 2'b11; prescale = 8'd0; compare = 24'hFFFFFF;
      cap_edge = 2'b01; cap_clr_cnt = 1'b0; trig_on_cap = 1'b1;
      pulse_start();
      wait_n(5);
      cap_pin = 1'b1;
      wait_n(3);
      chk("R9", "captured value", capture, 7);
      chk("R9", "cap_flag", cap_flag, 1);
      chk("R12", "trig on capture", trig_out, 1);
      cap_clr = 1'b1; @(negedge clk); cap_clr = 1'b0;
      cap_pin = 1'b0;
      wait_n(4);
      chk("R9", "falling ignored (flag)", cap_flag, 0);
      chk("R9", "falling ignored (value)", capture, 7);
      cap_edge = 2'b11;
      cap_pin = 1'b1;
      wait_n(3);
      chk("R9", "both edges captured", capture, 15);
   endtask

   task automatic t_capture_reset();
      cap_edge = 2'b01; cap_clr_cnt = 1'b1;
      cap_pin = 1'b0; wait_n(4);
      clear_flags();
      cap_pin = 1'b1;
      wait_n(3);
      chk("R10", "count cleared", count, 0);
      chk("R10", "cap_flag", cap_flag, 1);
      chk("R10", "capture untouched", capture, 15);
      wait_n(2); chk("R10", "count resumes", count, 2);
      clear_flags();
      trig_on_cap = 1'b0; cap_edge = 2'b11;
      cap_pin = 1'b0;
      wait_n(3);
      chk("R12", "capture trigger masked", trig_out, 0);
      chk("R10", "falling clears count (both)", count, 0);
      pulse_stop();
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      t_reset();
      t_periodic_prescale();
      t_oneshot();
      t_toggle();
      t_continuous();
      t_event();
      t_capture_latch();
      t_capture_reset();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (WDOG_CYCLES) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule